// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This peripheral gives a processor two independent up-counting timers, reached through a small register bus. Each timer keeps a running count, a limit and a two-bit control word. On every enabled tick the count goes up by one. When a tick arrives while the count equals the limit, the count returns to zero and the timer raises its interrupt, provided that interrupt enable is set. The interrupt is a level. It stays high until software writes that timer's control register, and any value written does this.

Software normally uses one timer as an event source and the other as a timestamp. For the event source it programs a limit, clears the count and writes enable plus halt-gating. Acknowledging each interrupt with enable set gives periodic operation. Acknowledging with enable clear gives one-shot operation. For the timestamp it sets the limit to all ones and leaves enable clear, so the counter wraps through the whole 32-bit range. The halt-gating bit stops a timer while the processor reports that it is halted.

Each timer has an interrupt state machine with three states:
- `ST_OFF`: enable is clear.
- `ST_ARMED`: enable is set and nothing is pending.
- `ST_FIRED`: the interrupt is pending.

Its transitions are:
- `ST_ARMED` to `ST_FIRED` on a limit match.
- Any state to `ST_OFF` on a control write with enable clear.
- Any state to `ST_ARMED` on a control write with enable set and no match in that cycle.
- Any state to `ST_FIRED` on a control write with enable set and a match in that cycle.
- `ST_OFF` and `ST_FIRED` hold in every other case.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, both interrupt outputs are low, the control words read 0, the limits read 0xFFFFFFFF and the counts start at 0. Each count then advances by one on every clock.
- R2: Address bit 2 selects the timer, and address bits 1:0 select the register: 0 is the count, 1 is the control word, 2 is the limit and 3 is a spare slot. The spare slot reads 0 and ignores writes. Read data is registered: it shows the addressed register as it was before the clock edge that samples the address.
- R3: Control bit 0 is interrupt enable and control bit 1 is halt-gating. Bits 31:2 read as 0 and ignore writes.
- R4: A timer ticks on every clock when halt-gating is 0. When halt-gating is 1, it ticks only while `cpu_halted` is low. Each tick adds one to the count.
- R5: A bus write to a count register takes effect in place of that cycle's increment, and no limit match is taken in that cycle.
- R6: A tick in which the count equals the limit loads the count with 0. If enable is set, the same edge raises the interrupt.
- R7: A raised interrupt stays high until its own control register is written.
- R8: Any control write clears the pending interrupt. If the written enable bit is 1, later matches raise the interrupt again (periodic use). If it is 0, no later match raises it (one-shot use).
- R9: When a control write and a limit match fall in the same cycle, the interrupt is high after that edge if the written enable bit is 1, and low if it is 0.
- R10: With the limit set to 0xFFFFFFFF and enable clear, the count runs from 0xFFFFFFFE to 0xFFFFFFFF to 0 and the interrupt stays low.
- R11: Writes and matches on one timer leave the other timer's registers and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_halted | input | 1 | High while the processor is halted |
| bus_addr | input | 3 | Register address: bit 2 selects the timer, bits 1:0 select the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| timer_irq | output | 2 | Level interrupt for each timer (bit 0 is timer 0) |

## Verification
A state machine stuck in the wrong state shows on `timer_irq` at the first edge where the correct next state would differ. Examples are an interrupt that drops without an acknowledge, or a match that goes missing while the timer is armed. A miscounting counter, or a wrong wrap value, is seen one edge after the count is read back over the bus. It is also seen as an interrupt that arrives one or more ticks off the limit-plus-one period. A wrong priority between a bus write and a match or an increment is exposed within one cycle of the collision, so the directed tests aim writes at exactly those edges.

// File: rtl/dit_pkg.sv
package dit_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } irq_state_e;

    localparam logic [1:0] SEL_COUNT = 2'd0;
    localparam logic [1:0] SEL_CTRL  = 2'd1;
    localparam logic [1:0] SEL_LIMIT = 2'd2;
    localparam logic [1:0] SEL_SPARE = 2'd3;

    localparam int IE_BIT = 0;
    localparam int NH_BIT = 1;

endpackage

// File: rtl/dit_counter.sv
module dit_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_count,
    input  logic              wr_limit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] limit,
    output logic              match
);

    // A match only counts on a real tick; a software count write displaces it.
    always_comb begin
        match = tick_en && !wr_count && (count == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_count) begin
            count <= wdata;
        end else if (tick_en) begin
            count <= match ? '0 : count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit <= '1;
        end else if (wr_limit) begin
            limit <= wdata;
        end
    end

endmodule

// File: rtl/dit_irq_fsm.sv
module dit_irq_fsm
    import dit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ie_wr,
    input  logic nh_wr,
    input  logic match,
    output logic irq,
    output logic ie,
    output logic nh
);

    irq_state_e state_q, state_nx;

    always_comb begin
        state_nx = state_q;
        if (ctrl_wr) begin
            // Acknowledge always clears; a coincident match re-fires when enabled.
            if (!ie_wr) begin
                state_nx = ST_OFF;
            end else if (match) begin
                state_nx = ST_FIRED;
            end else begin
                state_nx = ST_ARMED;
            end
        end else begin
            unique case (state_q)
                ST_OFF:   state_nx = ST_OFF;
                ST_ARMED: state_nx = match ? ST_FIRED : ST_ARMED;
                ST_FIRED: state_nx = ST_FIRED;
                default:  state_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nh <= 1'b0;
        end else if (ctrl_wr) begin
            nh <= nh_wr;
        end
    end

    always_comb begin
        irq = 1'b0;
        ie  = 1'b0;
        unique case (state_q)
            ST_OFF:   begin irq = 1'b0; ie = 1'b0; end
            ST_ARMED: begin irq = 1'b0; ie = 1'b1; end
            ST_FIRED: begin irq = 1'b1; ie = 1'b1; end
            default:  begin irq = 1'b0; ie = 1'b0; end
        endcase
    end

endmodule

// File: rtl/dit_bus_decode.sv
module dit_bus_decode
    import dit_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int DATA_W     = 32,
    parameter int TSEL_W     = 1,
    parameter int ADDR_W     = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic                                bus_we,
    input  logic [NUM_TIMERS-1:0][DATA_W-1:0]   count_q,
    input  logic [NUM_TIMERS-1:0][DATA_W-1:0]   limit_q,
    input  logic [NUM_TIMERS-1:0][DATA_W-1:0]   ctrl_q,
    output logic [NUM_TIMERS-1:0]               wr_count,
    output logic [NUM_TIMERS-1:0]               wr_ctrl,
    output logic [NUM_TIMERS-1:0]               wr_limit,
    output logic [DATA_W-1:0]                   bus_rdata
);

    logic [TSEL_W-1:0] tsel;
    logic [1:0]        rsel;
    logic [DATA_W-1:0] rd_nx;

    assign tsel = bus_addr[ADDR_W-1:2];
    assign rsel = bus_addr[1:0];

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_strobe
        logic hit;
        assign hit         = bus_we && (tsel == TSEL_W'(i));
        assign wr_count[i] = hit && (rsel == SEL_COUNT);
        assign wr_ctrl[i]  = hit && (rsel == SEL_CTRL);
        assign wr_limit[i] = hit && (rsel == SEL_LIMIT);
    end

    always_comb begin
        rd_nx = '0;
        if (int'(tsel) < NUM_TIMERS) begin
            unique case (rsel)
                SEL_COUNT: rd_nx = count_q[tsel];
                SEL_CTRL:  rd_nx = ctrl_q[tsel];
                SEL_LIMIT: rd_nx = limit_q[tsel];
                SEL_SPARE: rd_nx = '0;
                default:   rd_nx = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_nx;
        end
    end

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int DATA_W     = 32,
    parameter int TSEL_W     = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
    parameter int ADDR_W     = TSEL_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_halted,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_TIMERS-1:0] timer_irq
);

    logic [NUM_TIMERS-1:0][DATA_W-1:0] count_q;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] limit_q;
    logic [NUM_TIMERS-1:0][DATA_W-1:0] ctrl_q;
    logic [NUM_TIMERS-1:0]             wr_count;
    logic [NUM_TIMERS-1:0]             wr_ctrl;
    logic [NUM_TIMERS-1:0]             wr_limit;

    dit_bus_decode #(
        .NUM_TIMERS (NUM_TIMERS),
        .DATA_W     (DATA_W),
        .TSEL_W     (TSEL_W),
        .ADDR_W     (ADDR_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .count_q   (count_q),
        .limit_q   (limit_q),
        .ctrl_q    (ctrl_q),
        .wr_count  (wr_count),
        .wr_ctrl   (wr_ctrl),
        .wr_limit  (wr_limit),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_timer
        logic ie;
        logic nh;
        logic tick_en;
        logic match;

        // Halt-gating set: freeze while the processor is halted.
        assign tick_en = !nh || !cpu_halted;

        dit_counter #(
            .DATA_W (DATA_W)
        ) u_counter (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .wr_count (wr_count[i]),
            .wr_limit (wr_limit[i]),
            .wdata    (bus_wdata),
            .count    (count_q[i]),
            .limit    (limit_q[i]),
            .match    (match)
        );

        dit_irq_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_wr (wr_ctrl[i]),
            .ie_wr   (bus_wdata[IE_BIT]),
            .nh_wr   (bus_wdata[NH_BIT]),
            .match   (match),
            .irq     (timer_irq[i]),
            .ie      (ie),
            .nh      (nh)
        );

        always_comb begin
            ctrl_q[i]         = '0;
            ctrl_q[i][IE_BIT] = ie;
            ctrl_q[i][NH_BIT] = nh;
        end
    end

endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
    parameter int NUM_TIMERS = 2,
    parameter int DATA_W     = 32,
    parameter int TSEL_W     = 1,
    parameter int ADDR_W     = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_we,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NUM_TIMERS-1:0] timer_irq
);

    // R2: the spare slot always reads back as zero.
    assert_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] == 2'd3) |=> (bus_rdata == '0));

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_CNT  = {TSEL_W'(i), 2'd0};
        localparam logic [ADDR_W-1:0] A_CTRL = {TSEL_W'(i), 2'd1};

        // R7: a pending interrupt holds until its control register is written.
        assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (timer_irq[i] && !(bus_we && bus_addr == A_CTRL)) |=> timer_irq[i]);

        // R8: a control write with enable clear leaves the interrupt low.
        assert_ack_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == A_CTRL && !bus_wdata[0]) |=> !timer_irq[i]);

        // R3: the upper control bits read as zero.
        assert_ctrl_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_we && bus_addr == A_CTRL) |=> (bus_rdata[DATA_W-1:2] == '0));

        // R5: a count write is what the following read returns, not write+1.
        assert_count_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_we && bus_addr == A_CNT && $past(bus_we) && $past(bus_addr) == A_CNT)
            |=> (bus_rdata == $past(bus_wdata, 2)));
    end

endmodule

bind dual_interval_timer dit_checker #(
    .NUM_TIMERS (NUM_TIMERS),
    .DATA_W     (DATA_W),
    .TSEL_W     (TSEL_W),
    .ADDR_W     (ADDR_W)
) u_dit_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .timer_irq (timer_irq)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_halted = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  timer_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_interval_timer u_dual_interval_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_halted (cpu_halted),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .timer_irq  (timer_irq)
    );

    // Register addresses: bit 2 = timer, bits 1:0 = count/ctrl/limit/spare
    localparam logic [2:0] T0_CNT = 3'd0, T0_CTL = 3'd1, T0_LIM = 3'd2, T0_SPR = 3'd3;
    localparam logic [2:0] T1_CNT = 3'd4, T1_CTL = 3'd5, T1_LIM = 3'd6;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic test_reset();
        logic [31:0] v;
        chk("R1 irq after reset", {30'd0, timer_irq}, 32'd0);
        rd(T0_CTL, v); chk("R1 ctrl0 reset", v, 32'd0);
        rd(T1_LIM, v); chk("R1 limit1 reset", v, 32'hFFFF_FFFF);
        rd(T0_CNT, v); chk("R1 count0 runs from 0", v, 32'd2);
    endtask

    task automatic test_periodic_oneshot();
        logic [31:0] v;
        wr(T0_LIM, 32'd3);
        wr(T0_CNT, 32'd0);
        wr(T0_CTL, 32'd3);
        cyc(2); chk("R6 no irq before limit", {31'd0, timer_irq[0]}, 32'd0);
        cyc(1); chk("R6 irq on limit tick", {31'd0, timer_irq[0]}, 32'd1);
        rd(T0_CNT, v); chk("R6 count wrapped to 0", v, 32'd0);
        chk("R11 timer1 irq unaffected", {31'd0, timer_irq[1]}, 32'd0);
        cyc(5); chk("R7 irq held without ack", {31'd0, timer_irq[0]}, 32'd1);
        wr(T0_CTL, 32'd3); chk("R8 ack clears irq", {31'd0, timer_irq[0]}, 32'd0);
        cyc(1); chk("R8 periodic re-fire", {31'd0, timer_irq[0]}, 32'd1);
        cyc(3);
        wr(T0_CTL, 32'd3); chk("R9 ack with IE on match edge keeps irq", {31'd0, timer_irq[0]}, 32'd1);
        cyc(3);
        wr(T0_CTL, 32'd2); chk("R9 ack without IE on match edge drops irq", {31'd0, timer_irq[0]}, 32'd0);
        cyc(8); chk("R8 one-shot stays quiet", {31'd0, timer_irq[0]}, 32'd0);
    endtask

    task automatic test_halt_gate();
        logic [31:0] v;
        cpu_halted = 1'b1;
        wr(T0_CTL, 32'd2);
        wr(T0_CNT, 32'd50);
        cyc(5);
        rd(T0_CNT, v); chk("R4 gated count frozen while halted", v, 32'd50);
        cpu_halted = 1'b0;
        rd(T0_CNT, v); chk("R4 gated count at release", v, 32'd50);
        rd(T0_CNT, v); chk("R4 gated count resumes", v, 32'd51);
        cpu_halted = 1'b1;
        wr(T0_CTL, 32'd0);
        wr(T0_CNT, 32'd10);
        rd(T0_CNT, v); chk("R5 count write beats increment", v, 32'd10);
        rd(T0_CNT, v); chk("R4 ungated counts while halted", v, 32'd11);
        cpu_halted = 1'b0;
    endtask

    task automatic test_regs();
        logic [31:0] v;
        wr(T1_CTL, 32'hFFFF_FFFF);
        rd(T1_CTL, v); chk("R3 ctrl upper bits read 0", v, 32'd3);
        wr(T1_CTL, 32'd0);
        rd(T1_CTL, v); chk("R3 ctrl cleared", v, 32'd0);
        wr(T0_SPR, 32'h1234_5678);
        rd(T0_SPR, v); chk("R2 spare slot reads 0", v, 32'd0);
        rd(T0_LIM, v); chk("R2 spare write leaves limit", v, 32'd3);
    endtask

    task automatic test_free_run();
        logic [31:0] v;
        wr(T1_CTL, 32'd2);
        wr(T1_LIM, 32'hFFFF_FFFF);
        wr(T1_CNT, 32'hFFFF_FFFE);
        rd(T1_CNT, v); chk("R10 free-run start", v, 32'hFFFF_FFFE);
        rd(T1_CNT, v); chk("R10 free-run top", v, 32'hFFFF_FFFF);
        rd(T1_CNT, v); chk("R10 free-run wraps to 0", v, 32'd0);
        chk("R10 no irq when IE clear", {31'd0, timer_irq[1]}, 32'd0);
        rd(T0_LIM, v); chk("R11 timer0 limit untouched", v, 32'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_periodic_oneshot();
        test_halt_gate();
        test_regs();
        test_free_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule